// File: doc/BRIEF.md
# Supervisor Trap Entry Controller

This block holds the supervisor-level trap state of a small in-order core and decides, every cycle, whether the pipeline has to be steered to a new program counter. It watches three interrupt request lines (software, timer, external), a synchronous fault request with a cause code, a system-call indication and a return-from-trap request. Alongside these it takes the pc of the instruction now at the decision point and the privilege level it runs at. When any of these events is accepted, it raises a redirect in the same cycle, supplies the target pc and the new privilege level, and commits the whole register update at the next clock edge as one indivisible step.

Faults and system calls are never masked. Interrupts need three things at once: the global enable in the status register, the per-source enable bit and the request line itself. A return-from-trap reverses an entry by restoring the enable from its saved copy and dropping to the saved privilege level. Software reaches the registers through a plain address/data port. Reads are combinational. A write lands at the next edge unless that cycle commits a trap or a return.

The decision logic is an event selector with five named outcomes: EV_IDLE (nothing happens; CSR writes may land), EV_EXC (fault entry), EV_ECALL (system-call entry), EV_IRQ (interrupt entry) and EV_SRET (return). Every cycle takes exactly one of them, in the order EV_EXC, then EV_ECALL, then EV_IRQ, then EV_SRET, with EV_IDLE when none applies. The privilege level moves user→supervisor on any entry, supervisor→supervisor on an entry or on a return with the saved level at 1, and supervisor→user on a return with the saved level at 0.

Top module: `sup_trap_ctrl`

## Requirements
- R1: After reset, the status, enable, vector, saved-pc and cause registers all read 0, and redirect_o is low while no event is requested.
- R2: CSR addresses are status 0x100, enable 0x104, vector 0x105, saved pc 0x141, cause 0x142 and pending 0x144. Status keeps only bit 1 (global enable), bit 5 (saved enable) and bit 8 (saved level). The enable and pending registers use bit 1 for software, bit 5 for timer and bit 9 for external. The vector reads with its two low bits at 0. The pending register reads the live request lines and ignores writes.
- R3: An interrupt is accepted only when its line, its enable bit and the global enable are all 1. Otherwise redirect_o stays low and no register changes.
- R4: Among accepted interrupts, external wins over software, and software over timer. The cause register gets bit 31 set plus code 9 (external), 1 (software) or 5 (timer).
- R5: A fault request is accepted whatever the enables, and it beats a system call and any interrupt in the same cycle. The cause register gets the 4-bit fault code zero-extended with bit 31 clear.
- R6: A system call gives cause 8 at user level (priv_i = 0) and cause 9 at supervisor level (priv_i = 1).
- R7: On any trap entry, in the same cycle, redirect_o is 1, next_pc_o equals the vector and next_priv_o is 1. At the next edge the saved pc takes pc_i, the saved level takes priv_i, the saved enable takes the old global enable and the global enable becomes 0.
- R8: On a return, in the same cycle, redirect_o is 1, next_pc_o equals the saved pc and next_priv_o equals the saved level. At the next edge the global enable takes the saved enable, and the saved enable becomes 1 and the saved level 0.
- R9: A CSR write in a cycle that commits a trap entry or a return is discarded.
- R10: A trap entry requested in the same cycle as a return wins, and the return is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_sw_i | input | 1 | Software interrupt request line |
| irq_tmr_i | input | 1 | Timer interrupt request line |
| irq_ext_i | input | 1 | External interrupt request line |
| exc_valid_i | input | 1 | Synchronous fault request |
| exc_cause_i | input | 4 | Fault cause code |
| ecall_i | input | 1 | System-call instruction at the decision point |
| sret_i | input | 1 | Return-from-trap instruction at the decision point |
| pc_i | input | 32 | pc of the instruction at the decision point |
| priv_i | input | 1 | Current privilege level, 0 user, 1 supervisor |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| redirect_o | output | 1 | Pipeline must fetch from next_pc_o |
| next_pc_o | output | 32 | Target pc when redirecting |
| next_priv_o | output | 1 | Privilege level after this cycle |

## Verification
The interrupt path is swept over every mix of global enable, the three per-source enables, the three request lines and both privilege levels. This tells apart masking by the global enable, masking by a source enable and the priority order, and it shows that a refused interrupt leaves the saved pc, cause and status untouched. Fault codes are swept with every interrupt enabled and pending and with a system call present, which separates fault precedence from interrupt selection. Returns are tried with all four mixes of saved enable and saved level, so a swapped restore shows up. Collisions of a return with an interrupt, and of CSR writes with an entry or a return, show which action wins the commit.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int unsigned NSRC = 3;
    localparam int unsigned SRC_SW  = 0;
    localparam int unsigned SRC_TMR = 1;
    localparam int unsigned SRC_EXT = 2;

    localparam logic [11:0] CSR_SSTATUS = 12'h100;
    localparam logic [11:0] CSR_SIE     = 12'h104;
    localparam logic [11:0] CSR_STVEC   = 12'h105;
    localparam logic [11:0] CSR_SEPC    = 12'h141;
    localparam logic [11:0] CSR_SCAUSE  = 12'h142;
    localparam logic [11:0] CSR_SIP     = 12'h144;

    localparam int unsigned ST_GIE  = 1;
    localparam int unsigned ST_SPIE = 5;
    localparam int unsigned ST_SPP  = 8;

    localparam int unsigned CODE_ECALL_U = 8;
    localparam int unsigned CODE_ECALL_S = 9;

    localparam logic PRIV_U = 1'b0;
    localparam logic PRIV_S = 1'b1;

    typedef enum logic [2:0] {
        EV_IDLE  = 3'd0,
        EV_EXC   = 3'd1,
        EV_ECALL = 3'd2,
        EV_IRQ   = 3'd3,
        EV_SRET  = 3'd4
    } trap_ev_e;

    // Bit position of a source inside the enable/pending registers; it is
    // also the interrupt cause code of that source.
    function automatic int unsigned src_bit(input int unsigned src);
        return 1 + 4 * src;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               ecall,
    input  logic               sret,
    input  logic               priv,
    input  logic [NSRC-1:0]    irq_pend,
    input  logic [NSRC-1:0]    src_en,
    input  logic               g_ie,
    output trap_ev_e           ev,
    output logic [XLEN-1:0]    cause,
    output logic [NSRC-1:0]    grant
);

    logic [NSRC-1:0] armed;
    logic [XLEN-2:0] irq_code;

    // Per-source gating: line, source enable and global enable together.
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign armed[g] = irq_pend[g] & src_en[g] & g_ie;
    end

    // Fixed priority: external, then software, then timer.
    always_comb begin
        grant = '0;
        if (armed[SRC_EXT])      grant[SRC_EXT] = 1'b1;
        else if (armed[SRC_SW])  grant[SRC_SW]  = 1'b1;
        else if (armed[SRC_TMR]) grant[SRC_TMR] = 1'b1;
    end

    always_comb begin
        irq_code = '0;
        for (int unsigned s = 0; s < NSRC; s++) begin
            if (grant[s]) irq_code = (XLEN-1)'(src_bit(s));
        end
    end

    // Event selection: synchronous events first, return last.
    always_comb begin
        if (exc_valid)       ev = EV_EXC;
        else if (ecall)      ev = EV_ECALL;
        else if (|armed)     ev = EV_IRQ;
        else if (sret)       ev = EV_SRET;
        else                 ev = EV_IDLE;
    end

    always_comb begin
        cause = '0;
        unique case (ev)
            EV_EXC:   cause = XLEN'(exc_cause);
            EV_ECALL: cause = (priv == PRIV_S) ? XLEN'(CODE_ECALL_S)
                                               : XLEN'(CODE_ECALL_U);
            EV_IRQ:   cause = {1'b1, irq_code};
            EV_SRET:  cause = '0;
            EV_IDLE:  cause = '0;
            default:  cause = '0;
        endcase
    end

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic [NSRC-1:0] irq_pend,
    input  trap_ev_e        ev,
    input  logic [XLEN-1:0] cause,
    input  logic [XLEN-1:0] pc,
    input  logic            priv,
    output logic            g_ie,
    output logic            spie,
    output logic            spp,
    output logic [NSRC-1:0] src_en,
    output logic [XLEN-1:0] stvec,
    output logic [XLEN-1:0] sepc
);

    logic [XLEN-1:0] scause;

    // State register process: one commit per cycle, chosen by the event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_ie   <= 1'b0;
            spie   <= 1'b0;
            spp    <= PRIV_U;
            src_en <= '0;
            stvec  <= '0;
            sepc   <= '0;
            scause <= '0;
        end else begin
            unique case (ev)
                EV_EXC, EV_ECALL, EV_IRQ: begin
                    sepc   <= pc;
                    scause <= cause;
                    spp    <= priv;
                    spie   <= g_ie;
                    g_ie   <= 1'b0;
                end
                EV_SRET: begin
                    g_ie <= spie;
                    spie <= 1'b1;
                    spp  <= PRIV_U;
                end
                EV_IDLE: begin
                    if (csr_we) begin
                        case (csr_addr)
                            CSR_SSTATUS: begin
                                g_ie <= csr_wdata[ST_GIE];
                                spie <= csr_wdata[ST_SPIE];
                                spp  <= csr_wdata[ST_SPP];
                            end
                            CSR_SIE: begin
                                for (int unsigned s = 0; s < NSRC; s++) begin
                                    src_en[s] <= csr_wdata[src_bit(s)];
                                end
                            end
                            CSR_STVEC:  stvec  <= {csr_wdata[XLEN-1:2], 2'b00};
                            CSR_SEPC:   sepc   <= csr_wdata;
                            CSR_SCAUSE: scause <= csr_wdata;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            CSR_SSTATUS: begin
                csr_rdata[ST_GIE]  = g_ie;
                csr_rdata[ST_SPIE] = spie;
                csr_rdata[ST_SPP]  = spp;
            end
            CSR_SIE: begin
                for (int unsigned s = 0; s < NSRC; s++) begin
                    csr_rdata[src_bit(s)] = src_en[s];
                end
            end
            CSR_SIP: begin
                for (int unsigned s = 0; s < NSRC; s++) begin
                    csr_rdata[src_bit(s)] = irq_pend[s];
                end
            end
            CSR_STVEC:  csr_rdata = stvec;
            CSR_SEPC:   csr_rdata = sepc;
            CSR_SCAUSE: csr_rdata = scause;
            default:    csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sup_trap_ctrl.sv
module sup_trap_ctrl
    import trap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_sw_i,
    input  logic               irq_tmr_i,
    input  logic               irq_ext_i,
    input  logic               exc_valid_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               ecall_i,
    input  logic               sret_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               priv_i,
    input  logic               csr_we_i,
    input  logic [11:0]        csr_addr_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic               next_priv_o
);

    logic [NSRC-1:0] irq_pend;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] irq_grant;
    logic            g_ie;
    logic            spie;
    logic            spp;
    logic [XLEN-1:0] stvec_q;
    logic [XLEN-1:0] sepc_q;
    logic [XLEN-1:0] trap_cause;
    trap_ev_e        ev;

    always_comb begin
        irq_pend          = '0;
        irq_pend[SRC_SW]  = irq_sw_i;
        irq_pend[SRC_TMR] = irq_tmr_i;
        irq_pend[SRC_EXT] = irq_ext_i;
    end

    trap_arbiter #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) i_arb (
        .exc_valid (exc_valid_i),
        .exc_cause (exc_cause_i),
        .ecall     (ecall_i),
        .sret      (sret_i),
        .priv      (priv_i),
        .irq_pend  (irq_pend),
        .src_en    (src_en),
        .g_ie      (g_ie),
        .ev        (ev),
        .cause     (trap_cause),
        .grant     (irq_grant)
    );

    trap_csr_file #(
        .XLEN (XLEN)
    ) i_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we_i),
        .csr_addr  (csr_addr_i),
        .csr_wdata (csr_wdata_i),
        .csr_rdata (csr_rdata_o),
        .irq_pend  (irq_pend),
        .ev        (ev),
        .cause     (trap_cause),
        .pc        (pc_i),
        .priv      (priv_i),
        .g_ie      (g_ie),
        .spie      (spie),
        .spp       (spp),
        .src_en    (src_en),
        .stvec     (stvec_q),
        .sepc      (sepc_q)
    );

    // Output process: steering for the selected event.
    always_comb begin
        redirect_o  = 1'b0;
        next_pc_o   = pc_i;
        next_priv_o = priv_i;
        unique case (ev)
            EV_EXC, EV_ECALL, EV_IRQ: begin
                redirect_o  = 1'b1;
                next_pc_o   = stvec_q;
                next_priv_o = PRIV_S;
            end
            EV_SRET: begin
                redirect_o  = 1'b1;
                next_pc_o   = sepc_q;
                next_priv_o = spp;
            end
            EV_IDLE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/sup_trap_ctrl_chk.sv
module sup_trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_valid_i,
    input logic            ecall_i,
    input logic            sret_i,
    input logic [XLEN-1:0] pc_i,
    input logic            priv_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            next_priv_o,
    input trap_ev_e        ev,
    input logic            g_ie,
    input logic            spie,
    input logic            spp,
    input logic [XLEN-1:0] stvec_q,
    input logic [XLEN-1:0] sepc_q,
    input logic [NSRC-1:0] irq_grant
);

    // R3: with the global enable clear, only synchronous events or a return redirect
    a_r3_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && !ecall_i && !sret_i && !g_ie) |-> !redirect_o);

    // R4: at most one interrupt source granted
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_grant));

    // R5: faults are never masked
    a_r5_fault_taken: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |-> (redirect_o && next_priv_o && next_pc_o == stvec_q));

    // R7: entry commit
    a_r7_entry_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && ev != EV_SRET) |=>
        (!g_ie && spie == $past(g_ie) && spp == $past(priv_i) && sepc_q == $past(pc_i)));

    // R8: return target and restore
    a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SRET) |-> (redirect_o && next_pc_o == sepc_q && next_priv_o == spp));

    a_r8_return_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SRET) |=> (g_ie == $past(spie) && spie && !spp));

endmodule

bind sup_trap_ctrl sup_trap_ctrl_chk #(.XLEN(XLEN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid_i (exc_valid_i),
    .ecall_i     (ecall_i),
    .sret_i      (sret_i),
    .pc_i        (pc_i),
    .priv_i      (priv_i),
    .redirect_o  (redirect_o),
    .next_pc_o   (next_pc_o),
    .next_priv_o (next_priv_o),
    .ev          (ev),
    .g_ie        (g_ie),
    .spie        (spie),
    .spp         (spp),
    .stvec_q     (stvec_q),
    .sepc_q      (sepc_q),
    .irq_grant   (irq_grant)
);

// File: tb/test_sup_trap_ctrl.sv
`timescale 1ns/100ps
module test_sup_trap_ctrl;

    localparam logic [11:0] A_ST  = 12'h100;
    localparam logic [11:0] A_IE  = 12'h104;
    localparam logic [11:0] A_VEC = 12'h105;
    localparam logic [11:0] A_EPC = 12'h141;
    localparam logic [11:0] A_CAU = 12'h142;
    localparam logic [11:0] A_IP  = 12'h144;
    localparam logic [31:0] VEC   = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_sw = 0, irq_tmr = 0, irq_ext = 0;
    logic        exc_valid = 0;
    logic [3:0]  exc_cause = '0;
    logic        ecall = 0, sret = 0;
    logic [31:0] pc = '0;
    logic        priv = 0;
    logic        csr_we = 0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        redirect;
    logic [31:0] next_pc;
    logic        next_priv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sup_trap_ctrl i_sup_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_sw_i(irq_sw), .irq_tmr_i(irq_tmr), .irq_ext_i(irq_ext),
        .exc_valid_i(exc_valid), .exc_cause_i(exc_cause),
        .ecall_i(ecall), .sret_i(sret), .pc_i(pc), .priv_i(priv),
        .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata), .redirect_o(redirect),
        .next_pc_o(next_pc), .next_priv_o(next_priv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
        csr_addr = a;
        #0.5;
        d = csr_rdata;
    endtask

    task automatic idle_inputs();
        irq_sw = 0; irq_tmr = 0; irq_ext = 0;
        exc_valid = 0; ecall = 0; sret = 0; csr_we = 0;
    endtask

    function automatic logic [31:0] spread(input int m);
        return {22'd0, m[2], 3'd0, m[1], 3'd0, m[0], 1'b0};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 redirect", {31'd0, redirect}, 32'd0);
        csr_rd(A_ST, rd);  chk("R1 status", rd, 32'd0);
        csr_rd(A_IE, rd);  chk("R1 enable", rd, 32'd0);
        csr_rd(A_VEC, rd); chk("R1 vector", rd, 32'd0);
        csr_rd(A_EPC, rd); chk("R1 sepc", rd, 32'd0);
        csr_rd(A_CAU, rd); chk("R1 cause", rd, 32'd0);
        rst_n = 1'b1;

        // R2: field masks and pending view
        csr_wr(A_ST, 32'hFFFF_FFFF);  csr_rd(A_ST, rd);  chk("R2 status mask", rd, 32'h0000_0122);
        csr_wr(A_IE, 32'hFFFF_FFFF);  csr_rd(A_IE, rd);  chk("R2 enable mask", rd, 32'h0000_0222);
        csr_wr(A_VEC, 32'h1234_5677); csr_rd(A_VEC, rd); chk("R2 vector align", rd, 32'h1234_5674);
        csr_wr(A_EPC, 32'hCAFE_F00D); csr_rd(A_EPC, rd); chk("R2 sepc rw", rd, 32'hCAFE_F00D);
        csr_wr(A_CAU, 32'h0000_0017); csr_rd(A_CAU, rd); chk("R2 cause rw", rd, 32'h0000_0017);
        csr_wr(A_ST, 32'h0);
        csr_wr(A_IP, 32'hFFFF_FFFF);  csr_rd(A_IP, rd);  chk("R2 pending write ignored", rd, 32'h0);
        @(negedge clk); irq_tmr = 1; irq_ext = 1;
        csr_rd(A_IP, rd); chk("R2 pending lines", rd, 32'h0000_0220);
        irq_tmr = 0; irq_ext = 0;
        csr_wr(A_VEC, VEC);

        // R3/R4/R7: interrupt sweep
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 8; m++) begin
                for (int l = 0; l < 8; l++) begin
                    for (int p = 0; p < 2; p++) begin
                        int en;
                        int code;
                        bit take;
                        logic [31:0] mypc;
                        mypc = 32'h1000 + 32'((((g * 8 + m) * 8 + l) * 2 + p) * 4);
                        en = g ? (m & l) : 0;
                        take = (en != 0);
                        code = en[2] ? 9 : (en[0] ? 1 : 5);
                        csr_wr(A_ST, 32'(g) << 1);
                        csr_wr(A_IE, spread(m));
                        csr_wr(A_CAU, 32'h3C);
                        csr_wr(A_EPC, 32'h44);
                        @(negedge clk);
                        irq_sw = l[0]; irq_tmr = l[1]; irq_ext = l[2];
                        priv = p[0]; pc = mypc;
                        #1;
                        chk("R3 redirect gate", {31'd0, redirect}, {31'd0, take});
                        if (take) begin
                            chk("R7 entry target", next_pc, VEC);
                            chk("R7 entry level", {31'd0, next_priv}, 32'd1);
                        end
                        @(negedge clk);
                        idle_inputs();
                        csr_rd(A_CAU, rd);
                        chk("R4 cause", rd, take ? (32'h8000_0000 | 32'(code)) : 32'h3C);
                        csr_rd(A_EPC, rd);
                        chk("R7 sepc", rd, take ? mypc : 32'h44);
                        csr_rd(A_ST, rd);
                        chk("R7 status", rd, take ? ((32'(p) << 8) | 32'h20) : (32'(g) << 1));
                    end
                end
            end
        end

        // R5: faults beat system calls and interrupts
        for (int c = 0; c < 16; c++) begin
            csr_wr(A_ST, 32'h2);
            csr_wr(A_IE, 32'h222);
            @(negedge clk);
            exc_valid = 1; exc_cause = 4'(c); ecall = c[0];
            irq_sw = 1; irq_tmr = 1; irq_ext = 1; priv = 0; pc = 32'h2000 + 32'(c);
            #1;
            chk("R5 fault redirect", {31'd0, redirect}, 32'd1);
            chk("R5 fault target", next_pc, VEC);
            @(negedge clk);
            idle_inputs();
            csr_rd(A_CAU, rd); chk("R5 fault cause", rd, 32'(c));
        end
        csr_wr(A_ST, 32'h0);
        @(negedge clk); exc_valid = 1; exc_cause = 4'd13; #1;
        chk("R5 fault with enable clear", {31'd0, redirect}, 32'd1);
        @(negedge clk); idle_inputs();

        // R6: system call codes
        for (int p = 0; p < 2; p++) begin
            csr_wr(A_ST, 32'h0);
            @(negedge clk); ecall = 1; priv = p[0]; pc = 32'h3000; #1;
            chk("R6 ecall redirect", {31'd0, redirect}, 32'd1);
            @(negedge clk); idle_inputs();
            csr_rd(A_CAU, rd); chk("R6 ecall cause", rd, p ? 32'd9 : 32'd8);
            csr_rd(A_ST, rd);  chk("R6 ecall saved level", rd, 32'(p) << 8);
        end

        // R8: return, all saved-enable / saved-level mixes
        for (int k = 0; k < 4; k++) begin
            csr_wr(A_EPC, 32'h4400 + 32'(k * 16));
            csr_wr(A_ST, (32'(k & 1) << 5) | (32'(k >> 1) << 8));
            @(negedge clk); sret = 1; priv = 1; #1;
            chk("R8 return redirect", {31'd0, redirect}, 32'd1);
            chk("R8 return target", next_pc, 32'h4400 + 32'(k * 16));
            chk("R8 return level", {31'd0, next_priv}, 32'(k >> 1));
            @(negedge clk); idle_inputs();
            csr_rd(A_ST, rd); chk("R8 return status", rd, (32'(k & 1) << 1) | 32'h20);
        end

        // R10: interrupt beats a return
        csr_wr(A_IE, 32'h200);
        csr_wr(A_EPC, 32'h5550);
        csr_wr(A_ST, 32'h2);
        @(negedge clk); sret = 1; irq_ext = 1; priv = 1; pc = 32'h6000; #1;
        chk("R10 trap target over return", next_pc, VEC);
        @(negedge clk); idle_inputs();
        csr_rd(A_CAU, rd); chk("R10 cause", rd, 32'h8000_0009);
        csr_rd(A_EPC, rd); chk("R10 sepc", rd, 32'h6000);

        // R9: writes dropped on commit cycles
        csr_wr(A_ST, 32'h0);
        @(negedge clk); ecall = 1; priv = 0; pc = 32'h7000;
        csr_we = 1; csr_addr = A_EPC; csr_wdata = 32'hDEAD_BEEF;
        @(negedge clk); idle_inputs();
        csr_rd(A_EPC, rd); chk("R9 write during entry", rd, 32'h7000);
        csr_wr(A_CAU, 32'h11);
        @(negedge clk); sret = 1; priv = 1;
        csr_we = 1; csr_addr = A_CAU; csr_wdata = 32'h22;
        @(negedge clk); idle_inputs();
        csr_rd(A_CAU, rd); chk("R9 write during return", rd, 32'h11);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule